// File: doc/BRIEF.md
# Transmit Zero-Cross Detector

This block sits on the transmit side of a serial audio port and watches every sample as it is loaded into the output shift register. Each load carries a channel tag (left or right), the sample word and the active word width. For each channel the block keeps the sign bit of the last sample it accepted. When the next sample of that channel has a different sign bit, or when all of its bits within the active width are zero, the block raises that channel's zero-cross flag.

Detection only happens while transmission is active. Each channel has its own detection enable. The flags are sticky and are cleared by a one-cycle write-1 pulse. Each flag is gated by its own interrupt enable to form a per-channel interrupt output. The first accepted sample after reset, or after detection or transmission is re-enabled, only records the stored sign. It sets the flag only if it is all zeros.

Top module: `zc_detector`

## Requirements
- R1: After reset both flags and both interrupt outputs are 0.
- R2: A qualifying load sets the tagged channel's flag one clock later when its sign bit differs from that channel's stored sign. The sign bit is bit (width-1), with `word_code` 0, 1, 2, 3 selecting 8, 16, 24 or 32 bits.
- R3: A qualifying load whose bits below the active width are all zero sets the flag, including on a first sample. Bits at or above the active width are ignored for both the zero test and the sign.
- R4: The first qualifying load of a channel after reset, or after its detection enable or `tx_active` was low, only stores its sign. It sets no flag unless it is all zeros.
- R5: The channels keep independent histories. `load_chan` 0 tags left and 1 tags right, and a load never affects the other channel's flag or stored sign.
- R6: While a channel's detection enable is 0, its loads do not set its flag.
- R7: While `tx_active` is 0, no load sets any flag.
- R8: A flag stays set until its clear input is pulsed. A clear takes effect one clock later, and a detection in the same cycle as a clear wins, so the flag stays 1.
- R9: Each interrupt output equals its flag ANDed with its interrupt enable, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_active | input | 1 | Transmit path running |
| det_en_l | input | 1 | Left detection enable |
| det_en_r | input | 1 | Right detection enable |
| irq_en_l | input | 1 | Left interrupt enable |
| irq_en_r | input | 1 | Right interrupt enable |
| clr_l | input | 1 | Write-1 clear pulse for the left flag |
| clr_r | input | 1 | Write-1 clear pulse for the right flag |
| load_strobe | input | 1 | Sample loaded into the shift register this cycle |
| load_chan | input | 1 | Channel tag of the load (0 left, 1 right) |
| load_sample | input | 32 | Loaded sample, right-aligned |
| word_code | input | 2 | Active width code (0:8, 1:16, 2:24, 3:32 bits) |
| flag_l | output | 1 | Left zero-cross flag |
| flag_r | output | 1 | Right zero-cross flag |
| irq_l | output | 1 | Left interrupt |
| irq_r | output | 1 | Right interrupt |

## Verification
A load or clear presented before a rising edge shows up on the flags just after that edge, so flags lag their stimulus by exactly one clock. The interrupt outputs follow the flags and the interrupt enables with no extra delay. The bench drives inputs and compares every output at the falling edge. Its reference model advances once per rising edge, so each comparison sees the result due from the inputs of the previous cycle.

// File: rtl/zcd_pkg.sv
package zcd_pkg;
  localparam int unsigned SAMPLE_W = 32;
  localparam int unsigned NUM_CH   = 2;

  typedef enum logic [1:0] {WW_8 = 2'd0, WW_16 = 2'd1, WW_24 = 2'd2, WW_32 = 2'd3} wcode_e;

  // number of active bits for a width code
  function automatic int unsigned active_bits(logic [1:0] code);
    return 8 * (int'(code) + 1);
  endfunction

  // sign bit at the top of the active width
  function automatic logic sign_of(logic [SAMPLE_W-1:0] s, logic [1:0] code);
    logic [SAMPLE_W-1:0] sh;
    sh = s >> (active_bits(code) - 1);
    return sh[0];
  endfunction

  // true when every active bit is zero
  function automatic logic zero_of(logic [SAMPLE_W-1:0] s, logic [1:0] code);
    logic [SAMPLE_W-1:0] mask;
    mask = {SAMPLE_W{1'b1}} >> (SAMPLE_W - active_bits(code));
    return (s & mask) == '0;
  endfunction
endpackage

// File: rtl/zcd_lane.sv
module zcd_lane
  import zcd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arm,
  input  logic                hit,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [1:0]          wcode,
  output logic                evt
);
  logic prev_sign, primed;
  logic cur_sign, cur_zero, take;

  assign cur_sign = sign_of(sample, wcode);
  assign cur_zero = zero_of(sample, wcode);
  assign take     = hit & arm;
  assign evt      = take & (cur_zero | (primed & (cur_sign != prev_sign)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sign <= 1'b0;
      primed    <= 1'b0;
    end else if (!arm) begin
      primed    <= 1'b0;
    end else if (take) begin
      prev_sign <= cur_sign;
      primed    <= 1'b1;
    end
  end

  // R4
  first_take_primes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> primed);
endmodule

// File: rtl/zcd_flag.sv
module zcd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= (flag & ~clr) | evt;
  end

  assign irq = flag & irq_en;

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  // R2
  event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);
  // R8
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !flag);
endmodule

// File: rtl/zc_detector.sv
module zc_detector
  import zcd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_active,
  input  logic                det_en_l,
  input  logic                det_en_r,
  input  logic                irq_en_l,
  input  logic                irq_en_r,
  input  logic                clr_l,
  input  logic                clr_r,
  input  logic                load_strobe,
  input  logic                load_chan,
  input  logic [SAMPLE_W-1:0] load_sample,
  input  logic [1:0]          word_code,
  output logic                flag_l,
  output logic                flag_r,
  output logic                irq_l,
  output logic                irq_r
);
  logic [NUM_CH-1:0] det_en, irq_en, clr, evt, flag, irq;

  assign det_en = {det_en_r, det_en_l};
  assign irq_en = {irq_en_r, irq_en_l};
  assign clr    = {clr_r, clr_l};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit_c;
    assign hit_c = load_strobe & (load_chan == 1'(c));
    zcd_lane u_lane (
      .clk(clk), .rst_n(rst_n), .arm(tx_active & det_en[c]), .hit(hit_c),
      .sample(load_sample), .wcode(word_code), .evt(evt[c]));
    zcd_flag u_flag (
      .clk(clk), .rst_n(rst_n), .evt(evt[c]), .clr(clr[c]),
      .irq_en(irq_en[c]), .flag(flag[c]), .irq(irq[c]));
  end

  assign flag_l = flag[0];
  assign flag_r = flag[1];
  assign irq_l  = irq[0];
  assign irq_r  = irq[1];

  // R7
  idle_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |=> !($rose(flag_l) || $rose(flag_r)));
  // R6
  left_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en_l |=> !$rose(flag_l));
  // R5
  right_load_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_strobe && load_chan) |=> !$rose(flag_l));
  // R5
  left_load_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_strobe && !load_chan) |=> !$rose(flag_r));
endmodule

// File: tb/tb_zc_detector.sv
module tb_zc_detector;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_active = 0, det_en_l = 0, det_en_r = 0, irq_en_l = 0, irq_en_r = 0;
  logic clr_l = 0, clr_r = 0, load_strobe = 0, load_chan = 0;
  logic [31:0] load_sample = '0;
  logic [1:0]  word_code = 2'd0;
  logic flag_l, flag_r, irq_l, irq_r;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  zc_detector dut (.*);

  // behavioural reference model
  bit m_flag[2], m_prev[2], m_primed[2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin m_flag[c] = 0; m_prev[c] = 0; m_primed[c] = 0; end
    end else begin
      int bits;
      bit sgn, zer, ev, den, cl;
      bits = 8 * (word_code + 1);
      sgn = load_sample[bits-1];
      zer = 1;
      for (int i = 0; i < 32; i++) if (i < bits && load_sample[i]) zer = 0;
      for (int c = 0; c < 2; c++) begin
        den = (c == 0) ? det_en_l : det_en_r;
        cl  = (c == 0) ? clr_l : clr_r;
        ev  = 0;
        if (!(tx_active && den)) m_primed[c] = 0;
        else if (load_strobe && load_chan == c) begin
          ev = zer || (m_primed[c] && sgn != m_prev[c]);
          m_prev[c] = sgn; m_primed[c] = 1;
        end
        m_flag[c] = ev ? 1 : (cl ? 0 : m_flag[c]);
      end
    end
  end

  task automatic step(string tag);
    logic [3:0] act, exp;
    @(negedge clk);
    act = {flag_l, flag_r, irq_l, irq_r};
    exp = {m_flag[0], m_flag[1], m_flag[0] & irq_en_l, m_flag[1] & irq_en_r};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {fl,fr,il,ir} actual %b expected %b at %0t", tag, act, exp, $time);
    end
    load_strobe = 0; clr_l = 0; clr_r = 0;
  endtask

  task automatic load(bit ch, logic [31:0] s, logic [1:0] w, string tag);
    load_strobe = 1; load_chan = ch; load_sample = s; word_code = w;
    step(tag);
    step(tag);
  endtask

  initial begin
    step("R1 reset");
    step("R1 reset");
    rst_n = 1;
    step("R1 after reset");
    tx_active = 1; det_en_l = 1; det_en_r = 1; irq_en_l = 1;
    step("R9 enables");
    load(0, 32'h40, 2'd0, "R4 first left sample");
    load(0, 32'h41, 2'd0, "R2 same sign");
    load(0, 32'h80, 2'd0, "R2 sign change w8");
    load(1, 32'h01, 2'd0, "R5 right first");
    load(1, 32'hFF, 2'd0, "R5 right sign change");
    clr_l = 1; step("R8 clear left"); step("R8 clear left");
    load(0, 32'h100, 2'd0, "R3 zero in width 8");
    clr_l = 1; clr_r = 1; step("R8 clear both"); step("R9 irq low");
    load(0, 32'h8000_0000, 2'd3, "R2 sign change w32 (prev neg? )");
    load(0, 32'h0000_8000, 2'd1, "R2 w16 sign");
    load(0, 32'h0001_0000, 2'd1, "R3 upper bits ignored w16");
    load(1, 32'h0080_0000, 2'd2, "R2 w24 right");
    irq_en_r = 1; step("R9 right irq enable");
    clr_l = 1; load_strobe = 1; load_chan = 0; load_sample = 0; word_code = 0;
    step("R8 set beats clear"); step("R8 set beats clear");
    clr_l = 1; clr_r = 1; step("R8 clear"); step("R8 clear");
    det_en_l = 0;
    load(0, 32'h0, 2'd0, "R6 disabled zero");
    det_en_l = 1;
    load(0, 32'hFF, 2'd0, "R4 first after enable");
    tx_active = 0;
    load(1, 32'h0, 2'd0, "R7 idle zero");
    load(0, 32'h01, 2'd0, "R7 idle sign");
    tx_active = 1;
    load(0, 32'h01, 2'd0, "R4 first after tx restart");
    load(0, 32'h80, 2'd0, "R2 after restart");
    for (int n = 0; n < 3000; n++) begin
      tx_active = ($urandom_range(15) != 0);
      det_en_l = ($urandom_range(7) != 0); det_en_r = ($urandom_range(7) != 0);
      irq_en_l = $urandom_range(1); irq_en_r = $urandom_range(1);
      clr_l = ($urandom_range(5) == 0); clr_r = ($urandom_range(5) == 0);
      load_strobe = $urandom_range(1); load_chan = $urandom_range(1);
      load_sample = ($urandom_range(7) == 0) ? 32'h0 : $urandom;
      word_code = $urandom_range(3);
      step("R2 R3 R5 R8 random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); checks++; fails++; $display("FAIL watchdog expired"); end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule